// File: doc/BRIEF.md
# Compare and Conditional Jump Unit

This block keeps the outcome of the most recent unsigned compare as two stored flags, "below" and "equal". It then resolves jump requests against those flags. A compare strobe with two 16-bit operands updates the flags. A jump strobe carries a 3-bit condition selector, a 16-bit target and the current instruction pointer. One cycle later the unit reports whether the jump is taken and which address execution continues from. It also flags a selector code that is not a valid jump.

Every jump instruction is three bytes long: one opcode byte followed by the 16-bit target, low byte first. A jump that is not taken continues at the current pointer plus three, wrapping at 2^16. A taken jump continues at the target. The unit does no fetching, does no arithmetic other than the compare, and has no wider datapath.

Top module: `cju_top`

## Requirements
- R1: On a clock edge with `cmp_valid_i` high, the flags capture below = (`cmp_a_i` < `cmp_b_i`) and equal = (`cmp_a_i` == `cmp_b_i`). "Above" means neither flag is set.
- R2: The comparison is unsigned. 0xFFFF is above 0x0001.
- R3: The selector encoding is 000 equal, 001 not equal, 010 below, 011 below-or-equal, 100 above, 101 above-or-equal, 110 unconditional, 111 illegal.
- R4: Selector 110 is taken whatever the flags hold.
- R5: When a jump is taken, `next_ip_o` equals the `jmp_target_i` that came with the strobe.
- R6: When a legal jump is not taken, `next_ip_o` equals `ip_i` + 3 modulo 2^16.
- R7: Selector 111 gives `taken_o` = 0 and raises `illegal_o` for exactly one cycle.
- R8: The flags hold their value until the next compare strobe. Reset clears both flags, so the state after reset reads as "above".
- R9: `taken_o`, `next_ip_o` and `illegal_o` are registered and appear one cycle after the jump strobe. A jump in the same cycle as a compare is resolved against the flags from before that compare. In a cycle that follows no jump strobe, `taken_o` and `illegal_o` are 0.
- R10: During reset, `taken_o`, `illegal_o` and `next_ip_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 1 | Compare strobe |
| cmp_a_i | input | 16 | First compare operand |
| cmp_b_i | input | 16 | Second compare operand |
| jmp_valid_i | input | 1 | Jump strobe |
| jmp_sel_i | input | 3 | Jump condition selector |
| jmp_target_i | input | 16 | Jump target address |
| ip_i | input | 16 | Address of the jump instruction |
| taken_o | output | 1 | Jump taken |
| next_ip_o | output | 16 | Address to continue from |
| illegal_o | output | 1 | Illegal selector seen |

## Verification
Each condition code is driven with operand pairs that land on both sides of its decision. Together these pairs cover equal, below and above.

Operand pairs whose order differs between signed and unsigned readings show that the compare is unsigned. A pointer near 0xFFFF shows that the fall-through address wraps. A compare and a jump issued in the same cycle show that the stored flags, not the new operands, decide the jump. A run of jumps with no compare between them shows that the flags are held.

// File: rtl/cju_pkg.sv
package cju_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned JMP_LEN = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_EQ    = 3'b000,
    SEL_NE    = 3'b001,
    SEL_LT    = 3'b010,
    SEL_LE    = 3'b011,
    SEL_GT    = 3'b100,
    SEL_GE    = 3'b101,
    SEL_ALWAYS= 3'b110,
    SEL_BAD   = 3'b111
  } jsel_e;

  typedef struct packed {
    logic below;
    logic equal;
  } flags_t;
endpackage

// File: rtl/cju_flag_reg.sv
module cju_flag_reg
  import cju_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmp_valid_i,
  input  logic [W-1:0] cmp_a_i,
  input  logic [W-1:0] cmp_b_i,
  output flags_t       flags_o
);
  flags_t flags_d;

  always_comb begin
    flags_d.below = cmp_a_i < cmp_b_i;
    flags_d.equal = cmp_a_i == cmp_b_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flags_o <= '0;
    else if (cmp_valid_i) flags_o <= flags_d;
  end
endmodule

// File: rtl/cju_cond_eval.sv
module cju_cond_eval
  import cju_pkg::*;
(
  input  flags_t           flags_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             take_o,
  output logic             bad_o
);
  logic above;
  assign above = !flags_i.below && !flags_i.equal;

  always_comb begin
    take_o = 1'b0;
    bad_o  = 1'b0;
    unique case (jsel_e'(sel_i))
      SEL_EQ:     take_o = flags_i.equal;
      SEL_NE:     take_o = !flags_i.equal;
      SEL_LT:     take_o = flags_i.below;
      SEL_LE:     take_o = flags_i.below || flags_i.equal;
      SEL_GT:     take_o = above;
      SEL_GE:     take_o = !flags_i.below;
      SEL_ALWAYS: take_o = 1'b1;
      SEL_BAD:    bad_o  = 1'b1;
      default:    bad_o  = 1'b1;
    endcase
  end
endmodule

// File: rtl/cju_ip_select.sv
module cju_ip_select
  import cju_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned LEN = JMP_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          jmp_valid_i,
  input  logic          take_i,
  input  logic          bad_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] ip_i,
  output logic          taken_o,
  output logic          illegal_o,
  output logic [AW-1:0] next_ip_o
);
  localparam logic [AW-1:0] STEP = AW'(LEN);
  logic [AW-1:0] fall_ip;

  assign fall_ip = ip_i + STEP;  // wraps naturally at 2^AW

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o   <= 1'b0;
      illegal_o <= 1'b0;
      next_ip_o <= '0;
    end else begin
      taken_o   <= jmp_valid_i && take_i && !bad_i;
      illegal_o <= jmp_valid_i && bad_i;
      if (jmp_valid_i && !bad_i)
        next_ip_o <= take_i ? target_i : fall_ip;
    end
  end
endmodule

// File: rtl/cju_top.sv
module cju_top
  import cju_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_valid_i,
  input  logic [DATA_W-1:0] cmp_a_i,
  input  logic [DATA_W-1:0] cmp_b_i,
  input  logic              jmp_valid_i,
  input  logic [SEL_W-1:0]  jmp_sel_i,
  input  logic [ADDR_W-1:0] jmp_target_i,
  input  logic [ADDR_W-1:0] ip_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_ip_o,
  output logic              illegal_o
);
  flags_t flags;
  logic   take, bad;

  cju_flag_reg #(.W(DATA_W)) u_flags (
    .clk_i, .rst_ni, .cmp_valid_i, .cmp_a_i, .cmp_b_i, .flags_o(flags)
  );

  cju_cond_eval u_cond (
    .flags_i(flags), .sel_i(jmp_sel_i), .take_o(take), .bad_o(bad)
  );

  cju_ip_select #(.AW(ADDR_W), .LEN(JMP_LEN)) u_ip (
    .clk_i, .rst_ni, .jmp_valid_i, .take_i(take), .bad_i(bad),
    .target_i(jmp_target_i), .ip_i, .taken_o, .illegal_o, .next_ip_o
  );
endmodule

// File: rtl/cju_chk.sv
module cju_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        jmp_valid_i,
  input logic [2:0]  jmp_sel_i,
  input logic [15:0] jmp_target_i,
  input logic [15:0] ip_i,
  input logic        taken_o,
  input logic        illegal_o,
  input logic [15:0] next_ip_o
);
  // R7
  bad_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp_valid_i && jmp_sel_i == 3'b111 |=> illegal_o && !taken_o);
  // R4
  always_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp_valid_i && jmp_sel_i == 3'b110 |=> taken_o && next_ip_o == $past(jmp_target_i));
  // R6
  fall_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp_valid_i && jmp_sel_i != 3'b111 |=>
      (taken_o || next_ip_o == $past(ip_i) + 16'd3));
  // R5
  target_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jmp_valid_i |=> (!taken_o || next_ip_o == $past(jmp_target_i)));
  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jmp_valid_i |=> !taken_o && !illegal_o);
  // R7
  no_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(taken_o && illegal_o));
endmodule

bind cju_top cju_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .jmp_valid_i(jmp_valid_i), .jmp_sel_i(jmp_sel_i),
  .jmp_target_i(jmp_target_i), .ip_i(ip_i), .taken_o(taken_o),
  .illegal_o(illegal_o), .next_ip_o(next_ip_o)
);

// File: tb/cju_top_test.sv
module cju_top_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmp_valid_i = 1'b0;
  logic [15:0] cmp_a_i = '0, cmp_b_i = '0;
  logic        jmp_valid_i = 1'b0;
  logic [2:0]  jmp_sel_i = '0;
  logic [15:0] jmp_target_i = '0, ip_i = '0;
  logic        taken_o, illegal_o;
  logic [15:0] next_ip_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  cju_top uut (.*);

  // {a, b, sel, expected taken}
  localparam int NV = 14;
  localparam logic [35:0] VEC [NV] = '{
    {16'h0005, 16'h0005, 3'b000, 1'b1},
    {16'h0005, 16'h0006, 3'b000, 1'b0},
    {16'h0005, 16'h0006, 3'b001, 1'b1},
    {16'h0007, 16'h0007, 3'b001, 1'b0},
    {16'h0003, 16'h0009, 3'b010, 1'b1},
    {16'h0009, 16'h0003, 3'b010, 1'b0},
    {16'h0009, 16'h0009, 3'b011, 1'b1},
    {16'h000A, 16'h0009, 3'b011, 1'b0},
    {16'hFFFF, 16'h0001, 3'b100, 1'b1},
    {16'h0001, 16'hFFFF, 3'b100, 1'b0},
    {16'h8000, 16'h8000, 3'b101, 1'b1},
    {16'h0000, 16'h0001, 3'b101, 1'b0},
    {16'h0000, 16'h0001, 3'b110, 1'b1},
    {16'h1234, 16'h1234, 3'b110, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmp(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk_i);
    cmp_valid_i = 1'b1; cmp_a_i = a; cmp_b_i = b;
    @(negedge clk_i);
    cmp_valid_i = 1'b0;
  endtask

  // drives jump at a negedge, samples 1 ns after the registering edge
  task automatic do_jmp(input logic [2:0] sel, input logic [15:0] ip, input logic [15:0] tgt);
    @(negedge clk_i);
    jmp_valid_i = 1'b1; jmp_sel_i = sel; ip_i = ip; jmp_target_i = tgt;
    @(posedge clk_i); #1;
  endtask

  task automatic end_jmp();
    @(negedge clk_i);
    jmp_valid_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    // R10: outputs in reset
    chk("R10 taken", {31'd0, taken_o}, 0);
    chk("R10 illegal", {31'd0, illegal_o}, 0);
    chk("R10 next_ip", {16'd0, next_ip_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R8: cleared flags read as above
    do_jmp(3'b100, 16'h0010, 16'h0200);
    chk("R8 reset flags ja", {31'd0, taken_o}, 1);
    end_jmp();
    do_jmp(3'b000, 16'h0010, 16'h0200);
    chk("R8 reset flags je", {31'd0, taken_o}, 0);
    end_jmp();

    // R1 R2 R3 R4 R5 R6: table walk
    for (int i = 0; i < NV; i++) begin
      logic [15:0] ip, tgt;
      ip  = 16'h0100 + 16'(i * 16);
      tgt = 16'h4000 + 16'(i);
      do_cmp(VEC[i][35:20], VEC[i][19:4]);
      do_jmp(VEC[i][3:1], ip, tgt);
      chk($sformatf("R3 vec%0d taken", i), {31'd0, taken_o}, {31'd0, VEC[i][0]});
      chk($sformatf("R5/R6 vec%0d next_ip", i), {16'd0, next_ip_o},
          {16'd0, VEC[i][0] ? tgt : ip + 16'd3});
      end_jmp();
    end

    // R9: idle cycle after a jump
    @(posedge clk_i); #1;
    chk("R9 idle taken", {31'd0, taken_o}, 0);

    // R8: flags held across jumps with no compare
    do_cmp(16'h0002, 16'h0004);
    do_jmp(3'b010, 16'h0300, 16'h0500);
    end_jmp();
    do_jmp(3'b010, 16'h0303, 16'h0600);
    chk("R8 held below", {31'd0, taken_o}, 1);
    chk("R8 held target", {16'd0, next_ip_o}, 16'h0600);
    end_jmp();

    // R6: wraparound
    do_jmp(3'b000, 16'hFFFE, 16'h1111);
    chk("R6 wrap", {16'd0, next_ip_o}, 16'h0001);
    end_jmp();

    // R7: illegal pulse, then gone
    do_jmp(3'b111, 16'h0700, 16'h0800);
    chk("R7 illegal high", {31'd0, illegal_o}, 1);
    chk("R7 not taken", {31'd0, taken_o}, 0);
    end_jmp();
    @(posedge clk_i); #1;
    chk("R7 one cycle", {31'd0, illegal_o}, 0);

    // R9: compare and jump together use old flags (below set now)
    @(negedge clk_i);
    cmp_valid_i = 1'b1; cmp_a_i = 16'h0050; cmp_b_i = 16'h0050;
    jmp_valid_i = 1'b1; jmp_sel_i = 3'b000; ip_i = 16'h0900; jmp_target_i = 16'h0A00;
    @(posedge clk_i); #1;
    chk("R9 old flags je", {31'd0, taken_o}, 0);
    chk("R9 old flags ip", {16'd0, next_ip_o}, 16'h0903);
    @(negedge clk_i);
    cmp_valid_i = 1'b0; jmp_valid_i = 1'b0;
    do_jmp(3'b000, 16'h0910, 16'h0B00);
    chk("R1 new flags je", {31'd0, taken_o}, 1);
    end_jmp();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule